// File: doc/BRIEF.md
# Switchable Double-Speed Clock Generator

This block produces the timing strobes for an 8051-style processor core and its peripherals. It runs entirely on the oscillator clock. Every output is a one-cycle clock-enable, not a derived clock. It supports two speeds. In standard mode the oscillator is first halved, and a machine cycle of six CPU phases spans twelve oscillator periods. In double-speed mode the halving stage is bypassed for the CPU, and a machine cycle spans six oscillator periods.

Software writes a small control register. One bit requests double speed. Each of seven peripheral slots has a bit that keeps that peripheral on the halved rate whatever the CPU does. A requested speed change is adopted only when a machine cycle ends. The first phase of the new cycle always falls on a halved-clock edge, so no machine cycle is ever cut short. A pin sampled during reset can make the block leave reset already in double-speed mode. The readback shows the requested bits. The adopted CPU speed is reported on its own output.

Top module: `clkx2_gen`

## Requirements
- R1: While reset is held, `x2_active` equals `boot_x2`. `rd_data` equals `{7'b0, boot_x2}`. `phase` is 0.
- R2: `half_ce` is high on the first oscillator cycle after reset and then on every second cycle. While `x2_active` is 0, `cpu_ce` equals `half_ce`, so a machine cycle is 12 oscillator periods.
- R3: While `x2_active` is 1, `cpu_ce` is high on every cycle whose `phase` is not 0. The phase-0 tick still waits for `half_ce`. A machine cycle is therefore 6 oscillator periods.
- R4: `x2_active` takes the value of control bit 0 only in the cycle after a `cpu_ce` tick at `phase` 5. Each interval between `mc_strobe` pulses is exactly 12 or 6 periods, set by the mode of the cycle that began with the earlier strobe. This holds across switches in both directions.
- R5: `phase` advances by one, wrapping from 5 to 0, on each `cpu_ce` and holds otherwise. `mc_strobe` is high exactly when `cpu_ce` is high at `phase` 0. Such a tick always coincides with `half_ce`.
- R6: Peripheral slot k maps to control bit k+1, in the slot order timer 0, timer 1, timer 2, serial port, counter array, watchdog, CAN. When the slot's bit is 0 and `x2_active` is 1, `periph_ce[k]` is high on every cycle once the settings have been steady for three cycles.
- R7: When slot k's bit is 1, or `x2_active` is 0, `periph_ce[k]` equals `half_ce` once the settings have been steady for three cycles.
- R8: A cycle with `wr_en` high loads `wr_data` into the control register, and `rd_data` shows the new value from the next cycle. While `wr_en` is low, `rd_data` does not change whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_x2 | input | 1 | Nonvolatile option: leave reset in double-speed mode |
| wr_en | input | 1 | Control register write enable |
| wr_data | input | 8 | Control write data: bit 0 speed request, bits 7:1 peripheral hold-slow |
| rd_data | output | 8 | Control register readback |
| x2_active | output | 1 | Adopted CPU speed, 1 = double speed |
| half_ce | output | 1 | Halved oscillator edge strobe |
| cpu_ce | output | 1 | CPU phase tick |
| mc_strobe | output | 1 | Start of a machine cycle |
| phase | output | 3 | Current phase within the machine cycle, 0 to 5 |
| periph_ce | output | 7 | Per-peripheral clock-enable |

## Verification
The adopted speed and the phase counter are both visible at the ports. A speed flag adopted at the wrong time shows up in the first machine-cycle interval after the write, as a length of 6 where 12 was due or the reverse, and as `x2_active` disagreeing with the control bit sampled at the last phase tick. A phase counter that slips shows in the next cycle as a step other than plus one, or as a strobe off a halved edge. A wrong per-peripheral register shows within three cycles as an enable rate that does not match its control bit.

// File: rtl/clkx2_pkg.sv
package clkx2_pkg;

    localparam int unsigned MC_PHASES = 6;
    localparam int unsigned PERIPH_N  = 7;

    typedef enum logic {
        SPD_STD = 1'b0,
        SPD_DBL = 1'b1
    } speed_e;

    typedef struct packed {
        logic   tgl;
        speed_e mode;
    } clk_state_t;

    function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
        return (v >= lim - 1) ? 0 : v + 1;
    endfunction

    function automatic speed_e to_speed(logic b);
        return b ? SPD_DBL : SPD_STD;
    endfunction

endpackage

// File: rtl/clkx2_ctrl_reg.sv
module clkx2_ctrl_reg #(
    parameter int unsigned NUM_PERIPH = 7,
    localparam int unsigned CW = NUM_PERIPH + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boot_x2,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= {{NUM_PERIPH{1'b0}}, boot_x2};
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end
    end
endmodule

// File: rtl/clkx2_phase_gen.sv
module clkx2_phase_gen
    import clkx2_pkg::*;
#(
    parameter int unsigned PHASES = 6,
    localparam int unsigned PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boot_x2,
    input  logic          speed_req,
    output logic          half_ce,
    output logic          cpu_ce,
    output logic          mc_strobe,
    output logic [PW-1:0] phase,
    output logic          x2_act
);
    clk_state_t    st_q;
    logic [PW-1:0] ph_q;
    logic          last_ph;

    assign half_ce   = ~st_q.tgl;
    assign last_ph   = (ph_q == PW'(PHASES - 1));
    // phase 0 always waits for a halved edge; other phases run free in double speed
    assign cpu_ce    = half_ce | ((st_q.mode == SPD_DBL) && (ph_q != '0));
    assign mc_strobe = cpu_ce && (ph_q == '0);
    assign phase     = ph_q;
    assign x2_act    = (st_q.mode == SPD_DBL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.tgl  <= 1'b0;
            st_q.mode <= to_speed(boot_x2);
            ph_q      <= '0;
        end else begin
            st_q.tgl <= ~st_q.tgl;
            if (cpu_ce) begin
                ph_q <= PW'(wrap_inc(int'(ph_q), PHASES));
                if (last_ph) begin
                    st_q.mode <= to_speed(speed_req);
                end
            end
        end
    end
endmodule

// File: rtl/clkx2_periph_en.sv
module clkx2_periph_en #(
    parameter int unsigned NUM_PERIPH = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boot_x2,
    input  logic                  x2_act,
    input  logic                  half_ce,
    input  logic [NUM_PERIPH-1:0] hold_slow,
    output logic [NUM_PERIPH-1:0] periph_ce
);
    logic [NUM_PERIPH-1:0] fast_q;

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                fast_q[i] <= boot_x2;
            end else if (half_ce) begin
                fast_q[i] <= x2_act & ~hold_slow[i];
            end
        end
        assign periph_ce[i] = fast_q[i] | half_ce;
    end
endmodule

// File: rtl/clkx2_gen.sv
module clkx2_gen #(
    parameter int unsigned PHASES     = clkx2_pkg::MC_PHASES,
    parameter int unsigned NUM_PERIPH = clkx2_pkg::PERIPH_N,
    localparam int unsigned PW = $clog2(PHASES),
    localparam int unsigned CW = NUM_PERIPH + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boot_x2,
    input  logic                  wr_en,
    input  logic [CW-1:0]         wr_data,
    output logic [CW-1:0]         rd_data,
    output logic                  x2_active,
    output logic                  half_ce,
    output logic                  cpu_ce,
    output logic                  mc_strobe,
    output logic [PW-1:0]         phase,
    output logic [NUM_PERIPH-1:0] periph_ce
);
    logic [CW-1:0] ctrl_q;

    clkx2_ctrl_reg #(.NUM_PERIPH(NUM_PERIPH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .boot_x2 (boot_x2),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    clkx2_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .boot_x2   (boot_x2),
        .speed_req (ctrl_q[0]),
        .half_ce   (half_ce),
        .cpu_ce    (cpu_ce),
        .mc_strobe (mc_strobe),
        .phase     (phase),
        .x2_act    (x2_active)
    );

    clkx2_periph_en #(.NUM_PERIPH(NUM_PERIPH)) u_periph (
        .clk       (clk),
        .rst       (rst),
        .boot_x2   (boot_x2),
        .x2_act    (x2_active),
        .half_ce   (half_ce),
        .hold_slow (ctrl_q[CW-1:1]),
        .periph_ce (periph_ce)
    );

    assign rd_data = ctrl_q;
endmodule

// File: rtl/clkx2_chk.sv
module clkx2_chk #(
    parameter int unsigned PHASES     = 6,
    parameter int unsigned NUM_PERIPH = 7,
    localparam int unsigned PW = $clog2(PHASES),
    localparam int unsigned CW = NUM_PERIPH + 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  boot_x2,
    input logic                  wr_en,
    input logic [CW-1:0]         wr_data,
    input logic [CW-1:0]         rd_data,
    input logic                  x2_active,
    input logic                  half_ce,
    input logic                  cpu_ce,
    input logic                  mc_strobe,
    input logic [PW-1:0]         phase,
    input logic [NUM_PERIPH-1:0] periph_ce
);
    AST_STD_TICK_ON_HALF: assert property (@(posedge clk) disable iff (rst)
        !x2_active |-> (cpu_ce == half_ce)); // R2

    AST_DBL_TICK_EVERY_CLK: assert property (@(posedge clk) disable iff (rst)
        (x2_active && phase != '0) |-> cpu_ce); // R3

    AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (x2_active != $past(x2_active)) |-> $past(cpu_ce && phase == PW'(PHASES - 1))); // R4

    AST_STROBE_ON_HALF: assert property (@(posedge clk) disable iff (rst)
        mc_strobe |-> (half_ce && phase == '0)); // R5

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (cpu_ce && phase != PW'(PHASES - 1)) |=> (phase == $past(phase) + PW'(1))); // R5

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cpu_ce |=> $stable(phase)); // R5

    AST_SLOW_PERIPH_IN_STD: assert property (@(posedge clk) disable iff (rst)
        (!x2_active && $past(!x2_active)) |-> (periph_ce == {NUM_PERIPH{half_ce}})); // R7

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(rd_data)); // R8

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == $past(wr_data))); // R8
endmodule

bind clkx2_gen clkx2_chk #(.PHASES(PHASES), .NUM_PERIPH(NUM_PERIPH)) u_chk (.*);

// File: tb/clkx2_gen_tb.sv
`timescale 1ns/1ps
module clkx2_gen_tb;
    import clkx2_pkg::*;

    localparam int PH = MC_PHASES;
    localparam int NP = PERIPH_N;
    localparam int PW = $clog2(PH);
    localparam int CW = NP + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          boot_x2 = 1'b0;
    logic          wr_en = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] rd_data;
    logic          x2_active, half_ce, cpu_ce, mc_strobe;
    logic [PW-1:0] phase;
    logic [NP-1:0] periph_ce;

    int n_chk = 0;
    int n_bad = 0;
    int n_std_cyc = 0;
    int n_dbl_cyc = 0;
    logic [CW-1:0] shadow = '0;

    always #2 clk = ~clk;

    clkx2_gen u_dut (
        .clk(clk), .rst(rst), .boot_x2(boot_x2), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .x2_active(x2_active), .half_ce(half_ce), .cpu_ce(cpu_ce),
        .mc_strobe(mc_strobe), .phase(phase), .periph_ce(periph_ce)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cycle_len(input bit dbl);
        return dbl ? PH : 2 * PH;
    endfunction

    // port monitor, sampled at the falling edge
    bit exp_mode, par, seen, cyc_mode, prev_cpu, prev_x2;
    int cnt, stable;
    logic [PW-1:0] prev_ph;
    logic [CW-1:0] prev_rd;

    always @(negedge clk) begin
        if (rst) begin
            exp_mode = boot_x2; par = 1'b0; seen = 1'b0; cnt = 0; stable = 0;
            prev_cpu = 1'b0; prev_ph = '0; prev_x2 = boot_x2; prev_rd = rd_data;
        end else begin
            bit half_exp;
            half_exp = !par;
            chk(half_ce == half_exp, "R2", "half_ce", half_ce, half_exp);
            chk(x2_active == exp_mode, "R4", "x2_active", x2_active, exp_mode);
            if (exp_mode) begin
                if (phase == '0) chk(cpu_ce == half_exp, "R3", "cpu_ce phase0", cpu_ce, half_exp);
                else             chk(cpu_ce == 1'b1, "R3", "cpu_ce", cpu_ce, 1);
            end else begin
                chk(cpu_ce == half_exp, "R2", "cpu_ce", cpu_ce, half_exp);
            end
            chk(mc_strobe == (cpu_ce && phase == '0), "R5", "mc_strobe",
                mc_strobe, int'(cpu_ce && phase == '0));
            if (prev_cpu)
                chk(int'(phase) == (int'(prev_ph) + 1) % PH, "R5", "phase step",
                    phase, (int'(prev_ph) + 1) % PH);
            else
                chk(phase == prev_ph, "R5", "phase hold", phase, prev_ph);
            cnt++;
            if (mc_strobe) begin
                if (seen) begin
                    chk(cnt == cycle_len(cyc_mode), "R4", "machine cycle length",
                        cnt, cycle_len(cyc_mode));
                    if (cyc_mode) n_dbl_cyc++; else n_std_cyc++;
                end
                seen = 1'b1; cnt = 0; cyc_mode = exp_mode;
            end
            if (x2_active != prev_x2 || rd_data != prev_rd) stable = 0;
            else stable++;
            if (stable >= 3) begin
                for (int k = 0; k < NP; k++) begin
                    bit fast;
                    fast = exp_mode && !rd_data[k+1];
                    chk(periph_ce[k] == (fast | half_exp), fast ? "R6" : "R7",
                        $sformatf("periph_ce[%0d]", k), periph_ce[k], int'(fast | half_exp));
                end
            end
            if (cpu_ce && phase == PW'(PH - 1)) exp_mode = rd_data[0];
            par = ~par;
            prev_cpu = cpu_ce; prev_ph = phase; prev_x2 = x2_active; prev_rd = rd_data;
        end
    end

    task automatic apply_reset(input bit b);
        @(posedge clk); #1;
        rst = 1'b1; boot_x2 = b; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(x2_active == b, "R1", "x2_active in reset", x2_active, b);
        chk(rd_data == {{NP{1'b0}}, b}, "R1", "rd_data in reset", rd_data, {{NP{1'b0}}, b});
        chk(phase == '0, "R1", "phase in reset", phase, 0);
        shadow = {{NP{1'b0}}, b};
        rst = 1'b0;
    endtask

    task automatic write_ctrl(input logic [CW-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        shadow = d;
        chk(rd_data == shadow, "R8", "readback after write", rd_data, shadow);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        apply_reset(1'b0);
        idle(40);
        write_ctrl(8'h01);              // standard to double
        idle(40);
        write_ctrl(8'hFF);              // double, every peripheral held slow
        idle(30);
        write_ctrl(8'h00);              // back to standard
        idle(40);
        write_ctrl(8'h01); idle(3);     // request then cancel within a cycle
        write_ctrl(8'h00); idle(30);
        // writes blocked: data toggles while wr_en is low
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #1;
            wr_data = CW'($urandom);
            chk(rd_data == shadow, "R8", "readback without write", rd_data, shadow);
        end
        for (int i = 0; i < 150; i++) begin
            write_ctrl(CW'($urandom));
            idle($urandom_range(1, 30));
        end
        write_ctrl(8'h2B); idle(40);
        apply_reset(1'b1);              // start directly in double speed
        idle(40);
        write_ctrl(8'h00); idle(40);
        chk(n_std_cyc > 0, "R2", "standard cycles observed", n_std_cyc, 1);
        chk(n_dbl_cyc > 0, "R3", "double-speed cycles observed", n_dbl_cyc, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule